// File: doc/BRIEF.md
# UART Receive FIFO with Trigger and Timeout

This block queues characters coming out of a UART receive shifter until the host reads them. Each queued entry holds the 8-bit character and three error marks: parity, framing and break. The host sees the character at the head of the queue on `rd_data_o` together with that entry's error marks. A one-cycle `rd_i` pulse pops it.

The block derives the receive status that a line-status register and an interrupt controller consume. These are a data-ready flag, a sticky overrun flag, a flag that is set while any queued entry is errored, a fill-level interrupt condition with four selectable thresholds, and a character-timeout condition for a queue that holds data but is idle. The enable, flush and threshold-select fields of the FIFO control register arrive as plain inputs. With the FIFO disabled, the block behaves as a single holding register.

Top module: `uart_rx_fifo`

## Requirements
- R1: In FIFO mode the block stores up to 16 entries and returns them oldest first. `rd_data_o`, `head_perr_o`, `head_ferr_o` and `head_brk_o` show the oldest entry, and `level_o` gives the number of stored entries.
- R2: A character presented on `wr_valid_i` while the store is full (16 entries in FIFO mode) is dropped, even if a read happens in the same cycle. `overrun_o` is 1 from the following cycle.
- R3: `overrun_o` stays set until an `lsr_rd_i` pulse clears it. If a new overrun event and `lsr_rd_i` occur in the same cycle, the flag stays set.
- R4: `data_ready_o` is 1 exactly when at least one entry is stored. An `rd_i` pulse with data present removes one entry.
- R5: `fifo_err_o` is 1 while any stored entry has its parity, framing or break mark set.
- R6: `trig_o` is 1 when the fill level reaches the threshold chosen by `trig_sel_i`. The codes are 00 = 1, 01 = 4, 10 = 8 and 11 = 14 entries. In non-FIFO mode `trig_o` equals `data_ready_o`.
- R7: A `rx_flush_i` pulse empties the store from the next cycle. A character or read in the same cycle is ignored, and the flush does not change `overrun_o`.
- R8: The idle count restarts on any `wr_valid_i`, `rd_i` or flush, and while the store is empty; otherwise it advances once per clock. In FIFO mode `timeout_o` is 1 once the store is non-empty and the idle count has reached 4 × `char_time_i` clocks. A `char_time_i` of 0 disables the timeout.
- R9: With `fifo_en_i` low the capacity is one entry. A second character arriving before the first is read is dropped and sets `overrun_o`.
- R10: After reset the store is empty, and all flags and `level_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 = 16-entry FIFO mode, 0 = single holding register |
| rx_flush_i | input | 1 | One-cycle pulse that empties the store |
| trig_sel_i | input | 2 | Fill threshold select (00=1, 01=4, 10=8, 11=14) |
| char_time_i | input | 16 | Clock cycles per character time |
| wr_valid_i | input | 1 | A received character is presented this cycle |
| wr_data_i | input | 8 | Received character |
| wr_perr_i | input | 1 | Parity error mark for the character |
| wr_ferr_i | input | 1 | Framing error mark for the character |
| wr_brk_i | input | 1 | Break mark for the character |
| rd_i | input | 1 | Character read pulse (pops the head entry) |
| lsr_rd_i | input | 1 | Line status read pulse (clears overrun) |
| rd_data_o | output | 8 | Head entry character |
| head_perr_o | output | 1 | Head entry parity mark |
| head_ferr_o | output | 1 | Head entry framing mark |
| head_brk_o | output | 1 | Head entry break mark |
| data_ready_o | output | 1 | At least one entry stored |
| overrun_o | output | 1 | Sticky overrun flag |
| fifo_err_o | output | 1 | Some stored entry is errored |
| trig_o | output | 1 | Fill threshold reached |
| timeout_o | output | 1 | Character timeout condition |
| level_o | output | 5 | Number of stored entries |

## Verification
The queue is filled to exactly 16 entries and then offered a 17th character, alone and together with a read and a status read. This separates "full drops even with a read" from "read frees a slot", and "set wins" from "clear wins". Errored entries are placed between clean ones, so the error flag must follow the entries themselves rather than the latest write. The timeout is sampled before and after the 4-character window to catch an off-by-window counter. A disabled-FIFO pass shows a capacity of one rather than sixteen. Long mixed random traffic over all threshold codes is then compared against a queue model every cycle.

// File: rtl/uart_rx_fifo_pkg.sv
package uart_rx_fifo_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [CHAR_W-1:0] data;
  } rx_ent_t;

  function automatic logic ent_err(rx_ent_t e);
    return e.brk | e.ferr | e.perr;
  endfunction

  function automatic int unsigned trig_level(logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_fifo_store.sv
module uart_rx_fifo_store
  import uart_rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  rx_ent_t       push_ent_i,
  output rx_ent_t       head_o,
  output logic [CW-1:0] count_o,
  output logic          err_any_o
);
  rx_ent_t       mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q, err_q;

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      err_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      err_q <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= push_ent_i;
        wr_q        <= nxt(wr_q);
      end
      if (pop_i) rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
      // errored-entry count tracks pushes and pops of marked entries
      err_q <= err_q + CW'(push_i && ent_err(push_ent_i))
                     - CW'(pop_i && ent_err(mem_q[rd_q]));
    end
  end

  assign head_o    = mem_q[rd_q];
  assign count_o   = cnt_q;
  assign err_any_o = (err_q != '0);
endmodule

// File: rtl/uart_rx_fifo_tmo.sv
module uart_rx_fifo_tmo #(
  parameter int unsigned CT_W = 16,
  localparam int unsigned IW = CT_W + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            arm_i,
  input  logic [CT_W-1:0] char_time_i,
  output logic            expired_o
);
  logic [IW-1:0] idle_q, limit;

  assign limit = {char_time_i, 2'b00};  // four character times

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             idle_q <= '0;
    else if (restart_i)      idle_q <= '0;
    else if (idle_q < limit) idle_q <= idle_q + 1'b1;
  end

  assign expired_o = arm_i && (limit != '0) && (idle_q >= limit);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CT_W  = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              rx_flush_i,
  input  logic [1:0]        trig_sel_i,
  input  logic [CT_W-1:0]   char_time_i,
  input  logic              wr_valid_i,
  input  logic [CHAR_W-1:0] wr_data_i,
  input  logic              wr_perr_i,
  input  logic              wr_ferr_i,
  input  logic              wr_brk_i,
  input  logic              rd_i,
  input  logic              lsr_rd_i,
  output logic [CHAR_W-1:0] rd_data_o,
  output logic              head_perr_o,
  output logic              head_ferr_o,
  output logic              head_brk_o,
  output logic              data_ready_o,
  output logic              overrun_o,
  output logic              fifo_err_o,
  output logic              trig_o,
  output logic              timeout_o,
  output logic [CW-1:0]     level_o
);
  rx_ent_t       in_ent, head;
  logic [CW-1:0] cnt;
  logic          full, push, pop, ovr_evt, ovr_q, nonempty, err_any;

  assign in_ent   = '{brk: wr_brk_i, ferr: wr_ferr_i, perr: wr_perr_i, data: wr_data_i};
  assign nonempty = (cnt != '0);
  assign full     = fifo_en_i ? (cnt == CW'(DEPTH)) : nonempty;
  assign push     = wr_valid_i && !full && !rx_flush_i;
  assign pop      = rd_i && nonempty && !rx_flush_i;
  assign ovr_evt  = wr_valid_i && full && !rx_flush_i;

  uart_rx_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (rx_flush_i),
    .push_i     (push),
    .pop_i      (pop),
    .push_ent_i (in_ent),
    .head_o     (head),
    .count_o    (cnt),
    .err_any_o  (err_any)
  );

  uart_rx_fifo_tmo #(.CT_W(CT_W)) u_tmo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (wr_valid_i || rd_i || rx_flush_i || !nonempty),
    .arm_i       (fifo_en_i && nonempty),
    .char_time_i (char_time_i),
    .expired_o   (timeout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ovr_q <= 1'b0;
    else if (ovr_evt)  ovr_q <= 1'b1;  // new event beats a status read
    else if (lsr_rd_i) ovr_q <= 1'b0;
  end

  assign rd_data_o    = head.data;
  assign head_perr_o  = head.perr;
  assign head_ferr_o  = head.ferr;
  assign head_brk_o   = head.brk;
  assign data_ready_o = nonempty;
  assign overrun_o    = ovr_q;
  assign fifo_err_o   = err_any;
  assign level_o      = cnt;
  assign trig_o       = nonempty && (!fifo_en_i || (cnt >= CW'(trig_level(trig_sel_i))));
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fifo_en_i,
  input logic          rx_flush_i,
  input logic [1:0]    trig_sel_i,
  input logic          wr_valid_i,
  input logic          rd_i,
  input logic          lsr_rd_i,
  input logic          data_ready_o,
  input logic          overrun_o,
  input logic          fifo_err_o,
  input logic          trig_o,
  input logic          timeout_o,
  input logic [CW-1:0] level_o
);
  logic full_c, drop_c;
  assign full_c = fifo_en_i ? (level_o == CW'(DEPTH)) : (level_o != '0);
  assign drop_c = wr_valid_i && full_c && !rx_flush_i;

  p_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CW'(DEPTH));
  p_overrun_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_c |=> overrun_o);
  p_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_c && !rd_i |=> level_o == $past(level_o));
  p_lsr_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_rd_i && !drop_c |=> !overrun_o);
  p_pop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && data_ready_o && !rx_flush_i && !wr_valid_i |=> level_o == $past(level_o) - 1'b1);
  p_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_err_o |-> data_ready_o);
  p_trig14_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i && trig_sel_i == 2'b11 && trig_o |-> level_o >= CW'(14));
  p_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_i |=> level_o == '0);
  p_timeout_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> fifo_en_i && data_ready_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i && level_o == CW'(1) && wr_valid_i && !rd_i && !rx_flush_i |=> level_o == CW'(1));
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fifo_en_i    (fifo_en_i),
  .rx_flush_i   (rx_flush_i),
  .trig_sel_i   (trig_sel_i),
  .wr_valid_i   (wr_valid_i),
  .rd_i         (rd_i),
  .lsr_rd_i     (lsr_rd_i),
  .data_ready_o (data_ready_o),
  .overrun_o    (overrun_o),
  .fifo_err_o   (fifo_err_o),
  .trig_o       (trig_o),
  .timeout_o    (timeout_o),
  .level_o      (level_o)
);

// File: tb/tb_uart_rx_fifo.sv
`timescale 1ns/1ps
module tb_uart_rx_fifo;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        fifo_en_i = 1'b1, rx_flush_i = 1'b0;
  logic [1:0]  trig_sel_i = 2'b00;
  logic [15:0] char_time_i = 16'd5;
  logic        wr_valid_i = 1'b0, wr_perr_i = 1'b0, wr_ferr_i = 1'b0, wr_brk_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic        rd_i = 1'b0, lsr_rd_i = 1'b0;
  logic [7:0]  rd_data_o;
  logic        head_perr_o, head_ferr_o, head_brk_o;
  logic        data_ready_o, overrun_o, fifo_err_o, trig_o, timeout_o;
  logic [4:0]  level_o;

  int n_chk = 0, n_bad = 0;

  always #5 clk_i = ~clk_i;

  uart_rx_fifo dut (.*);

  // reference model: entry = {brk, ferr, perr, data}
  logic [10:0] mq[$];
  logic        m_ovr;
  int          m_idle;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mq.delete(); m_ovr = 1'b0; m_idle = 0;
    end else begin
      automatic int  pre  = mq.size();
      automatic bit  full = fifo_en_i ? (pre == 16) : (pre != 0);
      automatic int  lim  = 4 * int'(char_time_i);
      if (rx_flush_i) mq.delete();
      else begin
        if (rd_i && pre > 0) void'(mq.pop_front());
        if (wr_valid_i && !full) mq.push_back({wr_brk_i, wr_ferr_i, wr_perr_i, wr_data_i});
      end
      if (wr_valid_i && full && !rx_flush_i) m_ovr = 1'b1;
      else if (lsr_rd_i) m_ovr = 1'b0;
      if (wr_valid_i || rd_i || rx_flush_i || pre == 0) m_idle = 0;
      else if (m_idle < lim) m_idle++;
    end
  end

  function automatic int lvl(logic [1:0] s);
    case (s) 2'b00: return 1; 2'b01: return 4; 2'b10: return 8; default: return 14; endcase
  endfunction

  task automatic cmp(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, before the bench drives new inputs
  always @(negedge clk_i) if (rst_ni) begin
    automatic int  sz  = mq.size();
    automatic bit  err = 0;
    automatic int  lim = 4 * int'(char_time_i);
    foreach (mq[i]) if (mq[i][10:8] != 3'b000) err = 1;
    cmp("R1 level", level_o, sz);
    if (sz > 0) cmp("R1 head", {head_brk_o, head_ferr_o, head_perr_o, rd_data_o}, mq[0]);
    cmp("R4 data_ready", data_ready_o, sz != 0);
    cmp("R3 overrun", overrun_o, m_ovr);
    cmp("R5 fifo_err", fifo_err_o, err);
    cmp("R6 trig", trig_o, (sz != 0) && (!fifo_en_i || sz >= lvl(trig_sel_i)));
    cmp("R8 timeout", timeout_o, fifo_en_i && sz != 0 && lim != 0 && m_idle >= lim);
  end

  task automatic cyc(bit wv, logic [10:0] e, bit rd, bit lsr, bit fl);
    @(negedge clk_i); #2;
    wr_valid_i = wv; {wr_brk_i, wr_ferr_i, wr_perr_i, wr_data_i} = e;
    rd_i = rd; lsr_rd_i = lsr; rx_flush_i = fl;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    cmp("R10 level after reset", level_o, 0);
    cmp("R10 ready after reset", data_ready_o, 0);
    cmp("R10 overrun after reset", overrun_o, 0);
    cmp("R10 trig after reset", {trig_o, timeout_o, fifo_err_o}, 0);
    #2 rst_ni = 1'b1;
    idle(2);

    // fill to 16, then overflow
    for (int i = 0; i < 16; i++) cyc(1, 11'(8'h10 + i), 0, 0, 0);
    idle(1);
    cmp("R1 full level", level_o, 16);
    trig_sel_i = 2'b11;
    idle(1);
    cmp("R6 trig at 14 threshold", trig_o, 1);
    cyc(1, 11'h0AA, 0, 0, 0); idle(1);
    cmp("R2 overrun set", overrun_o, 1);
    cmp("R2 dropped level", level_o, 16);
    cmp("R2 head kept", rd_data_o, 8'h10);
    cyc(1, 11'h0BB, 1, 0, 0); idle(1);
    cmp("R2 drop with read level", level_o, 15);
    cyc(1, 11'h0CC, 0, 0, 0); cyc(1, 11'h0DD, 0, 1, 0); idle(1);
    cmp("R3 set wins over status read", overrun_o, 1);
    cyc(0, '0, 0, 1, 0); idle(1);
    cmp("R3 cleared by status read", overrun_o, 0);
    for (int s = 0; s < 4; s++) begin
      trig_sel_i = 2'(s);
      for (int i = 0; i < 5; i++) cyc(0, '0, 1, 0, 0);
    end
    idle(1);
    cmp("R4 drained", data_ready_o, 0);

    // error tracking
    trig_sel_i = 2'b01;
    cyc(1, 11'h011, 0, 0, 0); cyc(1, 11'h122, 0, 0, 0); cyc(1, 11'h433, 0, 0, 0);
    idle(1);
    cmp("R5 err present", fifo_err_o, 1);
    cyc(0, '0, 1, 0, 0); idle(1);
    cmp("R1 head parity mark", head_perr_o, 1);
    cyc(0, '0, 1, 0, 0); idle(1);
    cmp("R5 err remains for break entry", fifo_err_o, 1);
    cyc(0, '0, 1, 0, 0); idle(1);
    cmp("R5 err gone", fifo_err_o, 0);

    // timeout (4 x 5 clocks)
    cyc(1, 11'h055, 0, 0, 0); cyc(1, 11'h066, 0, 0, 0);
    idle(10);
    cmp("R8 no timeout inside window", timeout_o, 0);
    idle(15);
    cmp("R8 timeout after window", timeout_o, 1);
    cyc(0, '0, 1, 0, 0); idle(1);
    cmp("R8 read restarts window", timeout_o, 0);

    // flush
    cyc(1, 11'h077, 0, 0, 0); cyc(0, '0, 0, 0, 1); idle(1);
    cmp("R7 flush empties", level_o, 0);

    // non-FIFO mode
    fifo_en_i = 1'b0;
    cyc(1, 11'h0A1, 0, 0, 0); cyc(1, 11'h0B2, 0, 0, 0); idle(1);
    cmp("R9 single holding level", level_o, 1);
    cmp("R9 first kept", rd_data_o, 8'hA1);
    cmp("R9 overrun", overrun_o, 1);
    idle(30);
    cmp("R9 no timeout in non-FIFO mode", timeout_o, 0);
    cyc(0, '0, 1, 1, 0); fifo_en_i = 1'b1;

    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      automatic int r = $urandom_range(0, 99);
      if (r < 2) fifo_en_i = ~fifo_en_i;
      if (r >= 95) trig_sel_i = 2'($urandom);
      cyc($urandom_range(0, 99) < 45, 11'($urandom) & 11'h3FF | (($urandom_range(0, 9) == 0) ? 11'h400 : 11'h0),
          $urandom_range(0, 99) < 40, $urandom_range(0, 99) < 10, $urandom_range(0, 199) == 0);
      if (i % 500 == 250) idle(30);
    end
    idle(3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule